// File: doc/BRIEF.md
# Capture/Compare Channel Status Logic

This block is a single capture/compare channel of a timer. A counter value arrives from outside on every cycle. A mode input selects between compare operation and capture operation. In compare operation, the channel holds a 16-bit compare value and raises an event flag whenever the counter equals that value. In capture operation, every edge strobe stores the counter into the same register and raises the event flag.

An over-capture flag records that a capture arrived while the previous one was still flagged and unread. A software event strobe forces one capture or compare event, the same as real hardware would. The event flag is cleared in two ways: by reading the capture/compare register, or by a status write that carries a 0 in the flag's bit. Two requests follow the event flag: an interrupt request, gated by its enable, and a DMA request, gated by its own enable.

Top module: `ccx_channel`

## Requirements
- R1: With `mode_i`=0 (compare), the cycle after `cnt_i` equals `ccr_o`, `evt_o` is 1.
- R2: With `mode_i`=1 (capture), an `edge_i` pulse stores `cnt_i` into `ccr_o` and sets `evt_o`, both visible on the next cycle.
- R3: A status write (`sts_we_i`=1) with `sts_evt_i`=0 clears `evt_o`. With `sts_evt_i`=1, the write leaves `evt_o` unchanged.
- R4: A read strobe `rd_i` clears `evt_o` on the next cycle.
- R5: A capture while `evt_o`=1 sets `ovr_o` on the next cycle.
- R6: `ovr_o` clears only on a status write with `sts_ovr_i`=0. Reads and writes with `sts_ovr_i`=1 leave it set.
- R7: With `mode_i`=1, a `swev_i` pulse performs a capture identical to an edge, including the over-capture rule.
- R8: With `mode_i`=0, a `swev_i` pulse sets `evt_o` on the next cycle, whatever the counter value.
- R9: `irq_o` equals `evt_o` AND `irq_en_i`. `dreq_o` equals `evt_o` AND `dma_en_i`.
- R10: A set event (capture or compare) and a clearing read or write in the same cycle leave `evt_o` at 1.
- R11: After reset, `evt_o`, `ovr_o` and `ccr_o` are 0.
- R12: `ovr_o` never sets in compare mode.
- R13: `wr_i` loads `wdata_i` into `ccr_o`. A capture in the same cycle takes precedence over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CW | Counter value |
| mode_i | input | 1 | 0 = compare, 1 = capture |
| edge_i | input | 1 | Capture edge strobe |
| swev_i | input | 1 | Software event pulse, one cycle |
| wr_i | input | 1 | Write strobe for the compare register |
| wdata_i | input | CW | Compare register write data |
| rd_i | input | 1 | Read strobe for the capture/compare register |
| sts_we_i | input | 1 | Status write strobe |
| sts_evt_i | input | 1 | Written event-flag bit (0 clears) |
| sts_ovr_i | input | 1 | Written over-capture bit (0 clears) |
| irq_en_i | input | 1 | Interrupt enable |
| dma_en_i | input | 1 | DMA enable |
| ccr_o | output | CW | Capture/compare register |
| evt_o | output | 1 | Event flag |
| ovr_o | output | 1 | Over-capture flag |
| irq_o | output | 1 | Interrupt request |
| dreq_o | output | 1 | DMA request |

## Verification
The bench aims at the cycles where several things act on the flags at the same time. A capture that coincides with a clearing read or write exposes a design that lets the clear win: it would drop the event. A second capture before the first is read exposes a missing over-capture flag. A read, or a write of 1, exposes a design that clears the over-capture flag through those paths. A software event in each mode exposes a design that fails to latch the counter, or that sets the over-capture flag in compare mode. Captures that coincide with a register write expose the wrong precedence, because the register would then hold the written data instead of the counter.

// File: rtl/ccx_channel.sv
module ccx_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          mode_i,
  input  logic          edge_i,
  input  logic          swev_i,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          sts_we_i,
  input  logic          sts_evt_i,
  input  logic          sts_ovr_i,
  input  logic          irq_en_i,
  input  logic          dma_en_i,
  output logic [CW-1:0] ccr_o,
  output logic          evt_o,
  output logic          ovr_o,
  output logic          irq_o,
  output logic          dreq_o
);

  logic cap, cmp, set_evt, clr_evt, clr_ovr;

  assign cap     = mode_i & (edge_i | swev_i);
  assign cmp     = ~mode_i & ((cnt_i == ccr_o) | swev_i);
  assign set_evt = cap | cmp;
  assign clr_evt = rd_i | (sts_we_i & ~sts_evt_i);
  assign clr_ovr = sts_we_i & ~sts_ovr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_o <= '0;
      evt_o <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      if (cap)       ccr_o <= cnt_i;
      else if (wr_i) ccr_o <= wdata_i;

      if (set_evt)      evt_o <= 1'b1;
      else if (clr_evt) evt_o <= 1'b0;

      if (cap && evt_o) ovr_o <= 1'b1;
      else if (clr_ovr) ovr_o <= 1'b0;
    end
  end

  assign irq_o  = evt_o & irq_en_i;
  assign dreq_o = evt_o & dma_en_i;

  assert_match_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && cnt_i == ccr_o) |=> evt_o);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && edge_i) |=> (evt_o && ccr_o == $past(cnt_i)));

  assert_wr0_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we_i && !sts_evt_i && !edge_i && !swev_i && (mode_i || cnt_i != ccr_o)) |=> !evt_o);

  assert_wr1_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_we_i && sts_evt_i && !rd_i && evt_o) |=> evt_o);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !edge_i && !swev_i && (mode_i || cnt_i != ccr_o)) |=> !evt_o);

  assert_overcap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && (edge_i || swev_i) && evt_o) |=> ovr_o);

  assert_ovr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o && !(sts_we_i && !sts_ovr_i)) |=> ovr_o);

  assert_sw_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && swev_i) |=> (evt_o && ccr_o == $past(cnt_i)));

  assert_sw_compare_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && swev_i) |=> evt_o);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && edge_i && rd_i) |=> evt_o);

  assert_no_ovr_in_compare_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !ovr_o) |=> !ovr_o);

  assert_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !(mode_i && (edge_i || swev_i))) |=> ccr_o == $past(wdata_i));

endmodule

// File: tb/sim_ccx_channel.sv
`timescale 1ns/100ps
module sim_ccx_channel;
  localparam int CW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic [CW-1:0] cnt_i = '0, wdata_i = '0;
  logic mode_i = 0, edge_i = 0, swev_i = 0, wr_i = 0, rd_i = 0;
  logic sts_we_i = 0, sts_evt_i = 0, sts_ovr_i = 0, irq_en_i = 0, dma_en_i = 0;
  logic [CW-1:0] ccr_o;
  logic evt_o, ovr_o, irq_o, dreq_o;

  int errors = 0, checks = 0;
  int m_ccr = 0, m_evt = 0, m_ovr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ccx_channel #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .mode_i(mode_i), .edge_i(edge_i),
    .swev_i(swev_i), .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i),
    .sts_we_i(sts_we_i), .sts_evt_i(sts_evt_i), .sts_ovr_i(sts_ovr_i),
    .irq_en_i(irq_en_i), .dma_en_i(dma_en_i), .ccr_o(ccr_o), .evt_o(evt_o),
    .ovr_o(ovr_o), .irq_o(irq_o), .dreq_o(dreq_o));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: evaluated on each rising edge from the inputs held stable since the last step
  always @(posedge clk) begin
    int cap, hit, nccr, nevt, novr;
    if (!rst_n) begin
      m_ccr = 0; m_evt = 0; m_ovr = 0;
    end else begin
      cap = mode_i && (edge_i || swev_i);
      hit = !mode_i && (swev_i || int'(cnt_i) == m_ccr);
      nccr = m_ccr; nevt = m_evt; novr = m_ovr;
      if (cap) nccr = int'(cnt_i);
      else if (wr_i) nccr = int'(wdata_i);
      if (cap && m_evt) novr = 1;
      else if (sts_we_i && !sts_ovr_i) novr = 0;
      if (cap || hit) nevt = 1;
      else if (rd_i || (sts_we_i && !sts_evt_i)) nevt = 0;
      m_ccr = nccr; m_evt = nevt; m_ovr = novr;
    end
  end

  always @(posedge clk) begin
    #0.5;
    if (!done) begin
      chk("R2 model ccr", int'(ccr_o), m_ccr);
      chk("R1 model evt", int'(evt_o), m_evt);
      chk("R5 model ovr", int'(ovr_o), m_ovr);
      chk("R9 model irq", int'(irq_o), int'(m_evt != 0 && irq_en_i));
      chk("R9 model dreq", int'(dreq_o), int'(m_evt != 0 && dma_en_i));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    chk("R11 reset evt", int'(evt_o), 0);
    chk("R11 reset ovr", int'(ovr_o), 0);
    chk("R11 reset ccr", int'(ccr_o), 0);

    cnt_i = 100; wr_i = 1; wdata_i = 5; step();
    wr_i = 0; chk("R13 load", int'(ccr_o), 5);
    cnt_i = 5; irq_en_i = 1; step();
    cnt_i = 6;
    chk("R1 match", int'(evt_o), 1);
    chk("R9 irq", int'(irq_o), 1);
    sts_we_i = 1; sts_evt_i = 1; sts_ovr_i = 1; step();
    chk("R3 write1 keeps", int'(evt_o), 1);
    sts_evt_i = 0; step();
    chk("R3 write0 clears", int'(evt_o), 0);
    sts_we_i = 0; irq_en_i = 0; dma_en_i = 1; swev_i = 1; step();
    swev_i = 0;
    chk("R8 sw compare", int'(evt_o), 1);
    chk("R9 dreq", int'(dreq_o), 1);
    chk("R9 irq gated", int'(irq_o), 0);
    swev_i = 1; step();
    swev_i = 0;
    chk("R12 no ovr in compare", int'(ovr_o), 0);
    rd_i = 1; step();
    rd_i = 0;
    chk("R4 read clears", int'(evt_o), 0);

    mode_i = 1; cnt_i = 40; edge_i = 1; step();
    chk("R2 capture ccr", int'(ccr_o), 40);
    chk("R2 capture evt", int'(evt_o), 1);
    chk("R5 first no ovr", int'(ovr_o), 0);
    cnt_i = 41; wr_i = 1; wdata_i = 999; step();
    wr_i = 0;
    chk("R13 capture beats load", int'(ccr_o), 41);
    chk("R5 overcapture", int'(ovr_o), 1);
    edge_i = 0; rd_i = 1; step();
    rd_i = 0;
    chk("R4 read clears evt", int'(evt_o), 0);
    chk("R6 read keeps ovr", int'(ovr_o), 1);
    sts_we_i = 1; sts_evt_i = 0; sts_ovr_i = 1; step();
    sts_we_i = 0;
    chk("R6 write1 keeps ovr", int'(ovr_o), 1);
    cnt_i = 77; swev_i = 1; step();
    swev_i = 0;
    chk("R7 sw capture ccr", int'(ccr_o), 77);
    chk("R7 sw capture evt", int'(evt_o), 1);
    cnt_i = 78; edge_i = 1; rd_i = 1; step();
    edge_i = 0; rd_i = 0;
    chk("R10 capture beats read", int'(evt_o), 1);
    chk("R10 ccr", int'(ccr_o), 78);
    sts_we_i = 1; sts_evt_i = 1; sts_ovr_i = 0; step();
    sts_we_i = 0;
    chk("R6 write0 clears ovr", int'(ovr_o), 0);
    chk("R3 write1 keeps evt", int'(evt_o), 1);

    for (int i = 0; i < 3000; i++) begin
      cnt_i   = CW'((int'(cnt_i) + 1) % 32);
      if ($urandom_range(0, 63) == 0) mode_i = ~mode_i;
      edge_i  = ($urandom_range(0, 3) == 0);
      swev_i  = ($urandom_range(0, 7) == 0);
      rd_i    = ($urandom_range(0, 5) == 0);
      sts_we_i  = ($urandom_range(0, 7) == 0);
      sts_evt_i = $urandom_range(0, 1) != 0;
      sts_ovr_i = $urandom_range(0, 1) != 0;
      wr_i    = ($urandom_range(0, 9) == 0);
      wdata_i = CW'($urandom_range(0, 31));
      irq_en_i = $urandom_range(0, 1) != 0;
      dma_en_i = $urandom_range(0, 1) != 0;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule